// File: doc/BRIEF.md
# DSI Video-Mode Line Timing Generator

This block produces the horizontal and vertical timing frame that a display serial interface host needs when it streams video. Horizontal timing is counted in lane byte clocks: the block is told the sync time, the back porch time, the active time and the total line time, all in byte clocks. The front porch is not programmed. It is whatever is left of the line after sync, back porch and active. Vertical timing is counted in whole lines across four regions: sync, back porch, active and front porch. The vertical sync width is capped at 15 lines.

The block drives one flag per region on each axis and two sync levels with selectable polarity. It also gives a one-cycle frame-start pulse and sync-start and sync-end events. It decodes a video-mode type from three mode flags and passes the active packet size, in pixels, on to the packet assembler. The configuration inputs are static and may only change while `enable` is low. Lowering `enable` returns the frame to its origin. Packet assembly and the physical layer live elsewhere.

Top module: `dsi_line_timer`

## Requirements
- R1: While reset is held or `enable` is low, every region flag and every event output is 0 and each sync output sits at its inactive level.
- R2: While running, the byte-clock counter steps from 0 to `cfgHline`-1 and then wraps. The regions follow in order: sync for `cfgHsa` clocks, back porch for `cfgHbp` clocks, active for `cfgHact` clocks, and front porch for the rest of the line. Exactly one horizontal flag is high in each running cycle.
- R3: The line counter advances once per line wrap, from 0 to total-1, where the total is the effective sync width plus `cfgVbp`, `cfgVact` and `cfgVfp`. The vertical regions follow in order: sync, back porch, active, front porch.
- R4: The effective vertical sync width is `cfgVsa` when that is at most 15, and 15 otherwise.
- R5: `hsyncOut` is high during the horizontal sync region, inverted when `cfgPol[2]` is 1. `vsyncOut` is high during the vertical sync region, inverted when `cfgPol[1]` is 1.
- R6: `modeType` is decoded from `cfgModeFlags`, where bit0 means video, bit1 means burst and bit2 means sync pulse. The value 3'b101 gives 2'd0 (non-burst with sync pulses). The value 3'b001 gives 2'd1 (non-burst with sync events). Every other value gives 2'd2 (burst).
- R7: `frameStart` is high for exactly the byte clock with line 0 and byte 0.
- R8: `hsStart` is high at byte 0 of every running line. `hsEnd` is high at byte `cfgHsa` when `cfgHsa` is nonzero. `vsEnd` is high at byte 0 of the line equal to the effective sync width when that width is nonzero. Both end events are suppressed when `modeType` is 2'd1.
- R9: `cfgErr` is 1 exactly when `cfgHsa`+`cfgHbp`+`cfgHact` exceeds `cfgHline`.
- R10: `pktSize` equals `cfgHdisp`.
- R11: The first clock edge that samples `enable` high starts the run at line 0, byte 0. `frameStart` is therefore high in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low clears the frame position |
| cfgHsa | input | H_W | Horizontal sync time in byte clocks |
| cfgHbp | input | H_W | Horizontal back porch in byte clocks |
| cfgHact | input | H_W | Active time in byte clocks |
| cfgHline | input | H_W | Total line time in byte clocks |
| cfgHdisp | input | P_W | Horizontal display width in pixels |
| cfgVsa | input | V_W | Vertical sync lines (requested) |
| cfgVbp | input | V_W | Vertical back porch lines |
| cfgVact | input | V_W | Vertical active lines |
| cfgVfp | input | V_W | Vertical front porch lines |
| cfgPol | input | 2 | Bits [2:1]: hsync and vsync active-low selects |
| cfgModeFlags | input | 3 | Video, burst and sync-pulse flags |
| modeType | output | 2 | Decoded video-mode type |
| pktSize | output | P_W | Active packet size per line |
| hsaFlag | output | 1 | Horizontal sync region |
| hbpFlag | output | 1 | Horizontal back porch region |
| hactFlag | output | 1 | Horizontal active region |
| hfpFlag | output | 1 | Horizontal front porch region |
| vsaFlag | output | 1 | Vertical sync region |
| vbpFlag | output | 1 | Vertical back porch region |
| vactFlag | output | 1 | Vertical active region |
| vfpFlag | output | 1 | Vertical front porch region |
| hsyncOut | output | 1 | Horizontal sync level with polarity |
| vsyncOut | output | 1 | Vertical sync level with polarity |
| frameStart | output | 1 | First byte clock of the frame |
| hsStart | output | 1 | Start of horizontal sync |
| hsEnd | output | 1 | End of horizontal sync |
| vsEnd | output | 1 | End of vertical sync |
| cfgErr | output | 1 | Line too short for sync, back porch and active |

## Verification
Several outputs can fire in the same byte clock. At byte 0 of line 0, `frameStart` and `hsStart` rise together. At byte 0 of the first line after vertical sync, `vsEnd` rises together with `hsStart`. With a zero horizontal sync time, the sync-start event and the back porch flag share one cycle, and no end event appears. The bench runs whole frames in every mode and under both polarities, with these configurations among them. It compares every output on every clock with a behavioural model built from the requirements, so a miss or a duplicate in any coinciding cycle is reported.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [1:0] {
    MODE_SYNC_PULSE = 2'd0,
    MODE_SYNC_EVENT = 2'd1,
    MODE_BURST      = 2'd2
  } vidMode_e;

  // strobes from the horizontal control to the vertical datapath
  typedef struct packed {
    logic run;      // frame position is valid this cycle
    logic clr;      // next edge returns to the origin
    logic lineAdv;  // last byte clock of the line
  } tgStrobe_t;

  localparam int FLAG_VIDEO = 0;
  localparam int FLAG_BURST = 1;
  localparam int FLAG_PULSE = 2;

endpackage

// File: rtl/dtg_cfg.sv
module dtg_cfg
  import dtg_pkg::*;
#(
  parameter int H_W     = 12,
  parameter int V_W     = 11,
  parameter int VSA_MAX = 15
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [H_W-1:0] hsa,
  input  logic [H_W-1:0] hbp,
  input  logic [H_W-1:0] hact,
  input  logic [H_W-1:0] hline,
  input  logic [V_W-1:0] vsaReq,
  input  logic [2:0]     modeFlags,
  output logic [V_W-1:0] vsaEff,
  output vidMode_e       mode,
  output logic           cfgErr
);
  localparam int S_W = H_W + 2;
  localparam logic [V_W-1:0] VSA_CAP = V_W'(VSA_MAX);
  localparam logic [2:0] PAT_PULSE = 3'((1 << FLAG_VIDEO) | (1 << FLAG_PULSE));
  localparam logic [2:0] PAT_EVENT = 3'(1 << FLAG_VIDEO);

  logic [S_W-1:0] usedLen;

  always_comb begin
    vsaEff  = (vsaReq > VSA_CAP) ? VSA_CAP : vsaReq;
    usedLen = {2'b00, hsa} + {2'b00, hbp} + {2'b00, hact};
    cfgErr  = usedLen > {2'b00, hline};
    if (modeFlags == PAT_PULSE)      mode = MODE_SYNC_PULSE;
    else if (modeFlags == PAT_EVENT) mode = MODE_SYNC_EVENT;
    else                             mode = MODE_BURST;
  end

  p_vsa_sat_r4: assert property (@(posedge clk) disable iff (!rstN)
    (vsaReq > VSA_CAP) |-> (vsaEff == VSA_CAP));

  p_mode_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeFlags == 3'b101) |-> (mode == MODE_SYNC_PULSE));

endmodule

// File: rtl/dtg_hctrl.sv
module dtg_hctrl
  import dtg_pkg::*;
#(
  parameter int H_W = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic [H_W-1:0] hsa,
  input  logic [H_W-1:0] hbp,
  input  logic [H_W-1:0] hact,
  input  logic [H_W-1:0] hline,
  input  vidMode_e       mode,
  output tgStrobe_t      st,
  output logic           hsaFlag,
  output logic           hbpFlag,
  output logic           hactFlag,
  output logic           hfpFlag,
  output logic           hsStart,
  output logic           hsEnd
);
  localparam int S_W = H_W + 2;

  logic           run;
  logic [H_W-1:0] hCnt;
  logic [S_W-1:0] hPos, endSa, endBp, endAct;
  logic           lastByte;

  always_comb begin
    hPos     = {2'b00, hCnt};
    endSa    = {2'b00, hsa};
    endBp    = endSa + {2'b00, hbp};
    endAct   = endBp + {2'b00, hact};
    lastByte = (hPos + S_W'(1)) >= {2'b00, hline};
    st.run     = run;
    st.clr     = !enable;
    st.lineAdv = run && enable && lastByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run  <= 1'b0;
      hCnt <= '0;
    end else if (!enable) begin
      run  <= 1'b0;
      hCnt <= '0;
    end else if (!run) begin
      run  <= 1'b1;
    end else if (lastByte) begin
      hCnt <= '0;
    end else begin
      hCnt <= hCnt + H_W'(1);
    end
  end

  always_comb begin
    hsaFlag  = run && (hPos < endSa);
    hbpFlag  = run && (hPos >= endSa) && (hPos < endBp);
    hactFlag = run && (hPos >= endBp) && (hPos < endAct);
    hfpFlag  = run && (hPos >= endAct);
    hsStart  = run && (hCnt == '0);
    hsEnd    = run && (mode != MODE_SYNC_EVENT) && (hsa != '0) && (hCnt == hsa);
  end

  p_hstep_r2: assert property (@(posedge clk) disable iff (!rstN)
    (run && enable && !st.lineAdv) |=> (hCnt == $past(hCnt) + H_W'(1)));

  p_hregion_r2: assert property (@(posedge clk) disable iff (!rstN)
    run |-> ($countones({hsaFlag, hbpFlag, hactFlag, hfpFlag}) == 1));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> !(hsaFlag || hbpFlag || hactFlag || hfpFlag || hsStart || hsEnd));

  p_no_hend_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SYNC_EVENT) |-> !hsEnd);

endmodule

// File: rtl/dtg_vpath.sv
module dtg_vpath
  import dtg_pkg::*;
#(
  parameter int V_W = 11
) (
  input  logic           clk,
  input  logic           rstN,
  input  tgStrobe_t      st,
  input  logic           hsStart,
  input  logic [V_W-1:0] vsaEff,
  input  logic [V_W-1:0] vbp,
  input  logic [V_W-1:0] vact,
  input  logic [V_W-1:0] vfp,
  input  vidMode_e       mode,
  output logic           vsaFlag,
  output logic           vbpFlag,
  output logic           vactFlag,
  output logic           vfpFlag,
  output logic           frameStart,
  output logic           vsEnd
);
  localparam int T_W = V_W + 2;

  logic [V_W-1:0] vCnt;
  logic [T_W-1:0] vPos, endSa, endBp, endAct, vTot;
  logic           lastLine;

  always_comb begin
    vPos     = {2'b00, vCnt};
    endSa    = {2'b00, vsaEff};
    endBp    = endSa + {2'b00, vbp};
    endAct   = endBp + {2'b00, vact};
    vTot     = endAct + {2'b00, vfp};
    lastLine = (vPos + T_W'(1)) >= vTot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            vCnt <= '0;
    else if (st.clr)      vCnt <= '0;
    else if (st.lineAdv)  vCnt <= lastLine ? '0 : vCnt + V_W'(1);
  end

  always_comb begin
    vsaFlag    = st.run && (vPos < endSa);
    vbpFlag    = st.run && (vPos >= endSa) && (vPos < endBp);
    vactFlag   = st.run && (vPos >= endBp) && (vPos < endAct);
    vfpFlag    = st.run && (vPos >= endAct);
    frameStart = hsStart && (vCnt == '0);
    vsEnd      = hsStart && (mode != MODE_SYNC_EVENT) && (vsaEff != '0) && (vCnt == vsaEff);
  end

  p_vhold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!st.clr && !st.lineAdv) |=> $stable(vCnt));

  p_fs_line_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> hsStart);

  p_no_vend_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SYNC_EVENT) |-> !vsEnd);

endmodule

// File: rtl/dsi_line_timer.sv
module dsi_line_timer
  import dtg_pkg::*;
#(
  parameter int H_W     = 12,
  parameter int V_W     = 11,
  parameter int P_W     = 12,
  parameter int VSA_MAX = 15
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic [H_W-1:0] cfgHsa,
  input  logic [H_W-1:0] cfgHbp,
  input  logic [H_W-1:0] cfgHact,
  input  logic [H_W-1:0] cfgHline,
  input  logic [P_W-1:0] cfgHdisp,
  input  logic [V_W-1:0] cfgVsa,
  input  logic [V_W-1:0] cfgVbp,
  input  logic [V_W-1:0] cfgVact,
  input  logic [V_W-1:0] cfgVfp,
  input  logic [2:1]     cfgPol,
  input  logic [2:0]     cfgModeFlags,
  output logic [1:0]     modeType,
  output logic [P_W-1:0] pktSize,
  output logic           hsaFlag,
  output logic           hbpFlag,
  output logic           hactFlag,
  output logic           hfpFlag,
  output logic           vsaFlag,
  output logic           vbpFlag,
  output logic           vactFlag,
  output logic           vfpFlag,
  output logic           hsyncOut,
  output logic           vsyncOut,
  output logic           frameStart,
  output logic           hsStart,
  output logic           hsEnd,
  output logic           vsEnd,
  output logic           cfgErr
);
  vidMode_e       mode;
  logic [V_W-1:0] vsaEff;
  tgStrobe_t      st;

  dtg_cfg #(.H_W(H_W), .V_W(V_W), .VSA_MAX(VSA_MAX)) uCfg (
    .clk(clk), .rstN(rstN), .hsa(cfgHsa), .hbp(cfgHbp), .hact(cfgHact),
    .hline(cfgHline), .vsaReq(cfgVsa), .modeFlags(cfgModeFlags),
    .vsaEff(vsaEff), .mode(mode), .cfgErr(cfgErr)
  );

  dtg_hctrl #(.H_W(H_W)) uHctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .hsa(cfgHsa), .hbp(cfgHbp),
    .hact(cfgHact), .hline(cfgHline), .mode(mode), .st(st),
    .hsaFlag(hsaFlag), .hbpFlag(hbpFlag), .hactFlag(hactFlag),
    .hfpFlag(hfpFlag), .hsStart(hsStart), .hsEnd(hsEnd)
  );

  dtg_vpath #(.V_W(V_W)) uVpath (
    .clk(clk), .rstN(rstN), .st(st), .hsStart(hsStart), .vsaEff(vsaEff),
    .vbp(cfgVbp), .vact(cfgVact), .vfp(cfgVfp), .mode(mode),
    .vsaFlag(vsaFlag), .vbpFlag(vbpFlag), .vactFlag(vactFlag),
    .vfpFlag(vfpFlag), .frameStart(frameStart), .vsEnd(vsEnd)
  );

  assign modeType = mode;
  assign pktSize  = cfgHdisp;
  assign hsyncOut = hsaFlag ^ cfgPol[2];
  assign vsyncOut = vsaFlag ^ cfgPol[1];

  p_hsync_pol_r5: assert property (@(posedge clk) disable iff (!rstN)
    !hsaFlag |-> (hsyncOut == cfgPol[2]));

endmodule

// File: tb/dsi_line_timer_test.sv
`timescale 1ns/100ps
module dsi_line_timer_test;
  localparam int H_W = 12, V_W = 11, P_W = 12;

  logic clk = 0, rstN = 0, enable = 0;
  logic [H_W-1:0] cfgHsa = 3, cfgHbp = 2, cfgHact = 5, cfgHline = 14;
  logic [P_W-1:0] cfgHdisp = 640;
  logic [V_W-1:0] cfgVsa = 2, cfgVbp = 1, cfgVact = 3, cfgVfp = 2;
  logic [2:1] cfgPol = 2'b00;
  logic [2:0] cfgModeFlags = 3'b101;
  logic [1:0] modeType;
  logic [P_W-1:0] pktSize;
  logic hsaFlag, hbpFlag, hactFlag, hfpFlag, vsaFlag, vbpFlag, vactFlag, vfpFlag;
  logic hsyncOut, vsyncOut, frameStart, hsStart, hsEnd, vsEnd, cfgErr;

  always #2.5 clk = ~clk;

  dsi_line_timer uut (.*);

  int nChk = 0, nFail = 0;
  int mRun = 0, mH = 0, mV = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int vsaE();
    return (cfgVsa > 15) ? 15 : int'(cfgVsa);
  endfunction
  function automatic int vTot();
    return vsaE() + int'(cfgVbp) + int'(cfgVact) + int'(cfgVfp);
  endfunction
  function automatic int expMode();
    if (cfgModeFlags == 3'b101) return 0;
    if (cfgModeFlags == 3'b001) return 1;
    return 2;
  endfunction

  // behavioural position model (R11, R2, R3)
  always @(posedge clk) begin
    if (!rstN || !enable) begin mRun = 0; mH = 0; mV = 0; end
    else if (mRun == 0) mRun = 1;
    else if (mH + 1 >= int'(cfgHline)) begin
      mH = 0;
      mV = (mV + 1 >= vTot()) ? 0 : mV + 1;
    end else mH++;
  end

  always @(negedge clk) begin
    #1;
    if (!done) begin
      int a, b, c;
      bit [3:0] eh, ev;
      bit es, ee;
      a = int'(cfgHsa); b = a + int'(cfgHbp); c = b + int'(cfgHact);
      eh = 0; ev = 0;
      if (mRun != 0) begin
        eh = (mH < a) ? 4'b1000 : (mH < b) ? 4'b0100 : (mH < c) ? 4'b0010 : 4'b0001;
        a = vsaE(); b = a + int'(cfgVbp); c = b + int'(cfgVact);
        ev = (mV < a) ? 4'b1000 : (mV < b) ? 4'b0100 : (mV < c) ? 4'b0010 : 4'b0001;
      end
      chk({hsaFlag, hbpFlag, hactFlag, hfpFlag} == eh, "R2 hflags",
          int'({hsaFlag, hbpFlag, hactFlag, hfpFlag}), int'(eh));
      chk({vsaFlag, vbpFlag, vactFlag, vfpFlag} == ev, "R3 vflags",
          int'({vsaFlag, vbpFlag, vactFlag, vfpFlag}), int'(ev));
      chk(hsyncOut == (eh[3] ^ cfgPol[2]), "R5 hsync", int'(hsyncOut), int'(eh[3] ^ cfgPol[2]));
      chk(vsyncOut == (ev[3] ^ cfgPol[1]), "R5 vsync", int'(vsyncOut), int'(ev[3] ^ cfgPol[1]));
      es = (mRun != 0) && (mH == 0);
      chk(frameStart == (es && mV == 0), "R7 frameStart", int'(frameStart), int'(es && mV == 0));
      chk(hsStart == es, "R8 hsStart", int'(hsStart), int'(es));
      ee = (mRun != 0) && expMode() != 1 && cfgHsa != 0 && mH == int'(cfgHsa);
      chk(hsEnd == ee, "R8 hsEnd", int'(hsEnd), int'(ee));
      ee = es && expMode() != 1 && vsaE() != 0 && mV == vsaE();
      chk(vsEnd == ee, "R8 vsEnd", int'(vsEnd), int'(ee));
      chk(int'(modeType) == expMode(), "R6 mode", int'(modeType), expMode());
      chk(cfgErr == (int'(cfgHsa) + int'(cfgHbp) + int'(cfgHact) > int'(cfgHline)),
          "R9 err", int'(cfgErr), int'(int'(cfgHsa) + int'(cfgHbp) + int'(cfgHact) > int'(cfgHline)));
      chk(pktSize == cfgHdisp, "R10 pkt", int'(pktSize), int'(cfgHdisp));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runFrames(input int n);
    @(negedge clk); enable = 1;
    @(negedge clk); #2;
    chk(frameStart == 1, "R11 first cycle", int'(frameStart), 1);
    cyc(n * int'(cfgHline) * vTot() + 3);
    enable = 0;
    cyc(2);
  endtask

  initial begin
    cyc(4);
    #2;
    chk(!hsaFlag && !vsaFlag && !frameStart && !hsStart && hsyncOut == 0, "R1 reset",
        int'({hsaFlag, vsaFlag, frameStart, hsStart, hsyncOut}), 0);
    @(negedge clk); rstN = 1;
    cyc(3); #2;
    chk(!hsaFlag && !hsStart && vsyncOut == 0, "R1 enable low",
        int'({hsaFlag, hsStart, vsyncOut}), 0);
    // pulses mode, active-high syncs
    runFrames(2);
    // sync events mode, both active low
    cfgModeFlags = 3'b001; cfgPol = 2'b11;
    runFrames(1);
    // burst, zero hsync width
    cfgModeFlags = 3'b011; cfgPol = 2'b10; cfgHsa = 0; cfgHline = 10;
    runFrames(1);
    // vsync saturation
    cfgModeFlags = 3'b000; cfgPol = 2'b01; cfgHsa = 3; cfgHline = 14; cfgVsa = 20;
    @(negedge clk); enable = 1;
    begin
      int cnt = 0;
      do begin @(negedge clk); #2; end while (!frameStart);
      for (int i = 0; i < 14 * 21; i++) begin
        if (vsaFlag) cnt++;
        @(negedge clk); #2;
      end
      chk(cnt == 15 * 14, "R4 vsync saturates", cnt, 15 * 14);
    end
    enable = 0; cyc(2);
    // oversized line contents
    cfgVsa = 2; cfgHsa = 6; cfgHbp = 5; cfgHact = 5; cfgHdisp = 1080;
    @(negedge clk); #2;
    chk(cfgErr == 1, "R9 overflow", int'(cfgErr), 1);
    chk(pktSize == 1080, "R10 size", int'(pktSize), 1080);
    runFrames(1);
    // full mode decode sweep
    for (int f = 0; f < 8; f++) begin
      @(negedge clk); cfgModeFlags = 3'(f); #2;
      chk(int'(modeType) == ((f == 5) ? 0 : (f == 1) ? 1 : 2), "R6 sweep", int'(modeType),
          (f == 5) ? 0 : (f == 1) ? 1 : 2);
    end
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++; nFail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule